// File: doc/BRIEF.md
# Oscillator Startup Delay Timer

This block holds off use of a main crystal clock until the oscillator has had time to settle. It runs on the always-present slow clock. A single configuration write carries an enable bit and a start-up count. The write drops the "stable" indication at once, loads the count, and restarts a divide-by-eight prescaler. The count then falls by one on every eighth slow-clock cycle. When it runs out, the stable flag rises and stays high until the next write.

A separate mask bit selects whether the stable condition drives a level interrupt toward the processor. The current count is visible on an output, so software or a neighbouring block can watch the remaining wait. With an 8-bit count and a 32.768 kHz slow clock, the longest wait is about 62 ms.

Top module: `oscwait_timer`

## Requirements
- R1: After reset, `osc_stable` is 0, `osc_irq` is 0, `cnt_value` is 0, and the interrupt mask is 0.
- R2: A write (`cfg_wr` high at a rising edge) makes `osc_stable` 0 and `cnt_value` equal to `cfg_count` from that edge on.
- R3: With `cfg_osc_on` = 1, `cnt_value` drops by exactly one every eighth clock after the write edge. The first drop comes 8 edges after it. The prescaler restarts from zero on every write.
- R4: For a written count N ≥ 1 with the enable bit set, `osc_stable` rises exactly 8·N edges after the write edge. At that point `cnt_value` reads 0.
- R5: A written count of 0 with the enable bit set does not set `osc_stable` at the write edge. The flag rises 8 edges later.
- R6: `osc_irq` is high exactly while `osc_stable` and the mask bit are both 1. The mask bit is loaded from `mask_val` when `mask_wr` is high, and this is independent of configuration writes.
- R7: A write with `cfg_osc_on` = 0 clears `osc_stable`. After such a write, `cnt_value` keeps the written value, and `osc_stable` never rises until the next enabling write.
- R8: A write made while a countdown is running discards it. Timing restarts from the new count, measured from the new write edge.
- R9: Once `osc_stable` is 1, it and `cnt_value` = 0 hold steady until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; every register in the block runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_osc_on | input | 1 | Oscillator enable bit carried by the write |
| cfg_count | input | CNT_W (8) | Start-up count carried by the write |
| mask_wr | input | 1 | Mask write strobe |
| mask_val | input | 1 | New value of the interrupt mask bit |
| osc_stable | output | 1 | Main clock is valid |
| osc_irq | output | 1 | Level interrupt: stable and unmasked |
| cnt_value | output | CNT_W (8) | Remaining start-up count |

## Verification
Several properties are checked on every cycle:
- A write always leaves the stable flag low on the next cycle.
- The flag is only ever high with a zero count.
- The count never falls by more than one per cycle and never rises without a write.
- Prescaler ticks are never adjacent.
- A disabled timer holds both its count and its flag.
- A reached stable state is kept.

Only the bench's scenarios can show the things that depend on long windows or on the written value:
- the exact 8·N edge latency;
- the special zero-count case;
- restart on a rewrite in mid-countdown;
- the way the mask combines with the flag.

// File: rtl/oscwait_pkg.sv
package oscwait_pkg;

    parameter int CNT_W_DEF  = 8;
    parameter int DIV_W_DEF  = 3;

    typedef struct packed {
        logic                 en;
        logic                 stable;
        logic [CNT_W_DEF-1:0] cnt;
    } cd_state_t;

    typedef struct packed {
        logic mask;
    } irq_state_t;

endpackage

// File: rtl/oscwait_prescale.sv
module oscwait_prescale #(
    parameter int DIV_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam logic [DIV_W-1:0] LAST = {DIV_W{1'b1}};

    logic [DIV_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (restart || !run) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = run && !restart && (pre_q == LAST);

    // R3: divided ticks are never on consecutive cycles
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/oscwait_countdown.sv
module oscwait_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_on,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             en,
    output logic             stable,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             en;
        logic             stable;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.en     = load_on;
            s_d.cnt    = load_val;
            s_d.stable = 1'b0;
        end else if (s_q.en && tick && !s_q.stable) begin
            if (s_q.cnt <= ONE) begin
                s_d.cnt    = '0;
                s_d.stable = 1'b1;
            end else begin
                s_d.cnt    = s_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en     = s_q.en;
    assign stable = s_q.stable;
    assign cnt    = s_q.cnt;

    // R5/R4: flag only ever high with the count exhausted
    p_stable_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stable |-> (cnt == '0));

    // R3: without a load the count holds or falls by one
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - ONE));

    // R7: a disabled timer is frozen and never stable
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> (!stable && $stable(cnt)));

    // R9: reached stable state persists until a write
    p_stable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stable && !load) |=> (stable && cnt == '0));

endmodule

// File: rtl/oscwait_irq.sv
module oscwait_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_wr,
    input  logic mask_val,
    input  logic stable,
    output logic irq
);
    import oscwait_pkg::*;

    irq_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (mask_wr) r_d.mask = mask_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq = stable && r_q.mask;

endmodule

// File: rtl/oscwait_timer.sv
module oscwait_timer #(
    parameter int CNT_W = 8,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_osc_on,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             mask_wr,
    input  logic             mask_val,
    output logic             osc_stable,
    output logic             osc_irq,
    output logic [CNT_W-1:0] cnt_value
);
    logic tick;
    logic en;

    oscwait_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_wr),
        .run     (en),
        .tick    (tick)
    );

    oscwait_countdown #(.CNT_W(CNT_W)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_wr),
        .load_on  (cfg_osc_on),
        .load_val (cfg_count),
        .tick     (tick),
        .en       (en),
        .stable   (osc_stable),
        .cnt      (cnt_value)
    );

    oscwait_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_wr  (mask_wr),
        .mask_val (mask_val),
        .stable   (osc_stable),
        .irq      (osc_irq)
    );

    // R2: a write always drops the stable flag on the following cycle
    p_wr_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !osc_stable);

    // R6: an interrupt never appears without the flag
    p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        osc_irq |-> osc_stable);

endmodule

// File: tb/test_oscwait_timer.sv
module test_oscwait_timer;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_osc_on = 1'b0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic             mask_wr = 1'b0;
    logic             mask_val = 1'b0;
    logic             osc_stable;
    logic             osc_irq;
    logic [CNT_W-1:0] cnt_value;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic mask_m = 1'b0;
    bit done = 1'b0;

    oscwait_timer #(.CNT_W(CNT_W)) i_oscwait_timer (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_osc_on(cfg_osc_on),
        .cfg_count(cfg_count), .mask_wr(mask_wr), .mask_val(mask_val),
        .osc_stable(osc_stable), .osc_irq(osc_irq), .cnt_value(cnt_value)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        wait (cyc > 150000);
        bad++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
        finish_up();
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_cnt(input bit on, input int n, input int k);
        int v;
        if (!on) return n;
        v = n - k / 8;
        return (v < 0) ? 0 : v;
    endfunction

    function automatic bit exp_stb(input bit on, input int n, input int k);
        int lim;
        lim = (n < 1) ? 8 : 8 * n;
        return on && (k >= lim);
    endfunction

    // write with optional mask update in the same cycle; leaves bench at k=0
    task automatic do_write(input bit on, input int n, input bit set_mask, input bit m);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_osc_on = on; cfg_count = CNT_W'(n);
        mask_wr = set_mask; mask_val = m;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; mask_wr = 1'b0;
        if (set_mask) mask_m = m;
    endtask

    task automatic check_at(input string tag, input bit on, input int n, input int k);
        bit s;
        s = exp_stb(on, n, k);
        chk({tag, " cnt"}, int'(cnt_value), exp_cnt(on, n, k));
        chk({tag, " stable"}, int'(osc_stable), int'(s));
        chk("R6 irq", int'(osc_irq), int'(s && mask_m));
    endtask

    // run k = 0..kmax after a write, checking every cycle
    task automatic run(input string tag, input bit on, input int n, input int kmax);
        check_at(tag, on, n, 0);
        for (int k = 1; k <= kmax; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_at(tag, on, n, k);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 stable", int'(osc_stable), 0);
        chk("R1 irq", int'(osc_irq), 0);
        chk("R1 cnt", int'(cnt_value), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle stable", int'(osc_stable), 0);

        // R5 zero count, mask enabled
        do_write(1'b1, 0, 1'b1, 1'b1);
        run("R5", 1'b1, 0, 14);
        // R4 / R9 small counts with trailing hold
        do_write(1'b1, 1, 1'b0, 1'b0);
        run("R4", 1'b1, 1, 20);
        do_write(1'b1, 3, 1'b0, 1'b0);
        run("R9", 1'b1, 3, 40);
        // R4 full-scale count
        do_write(1'b1, 255, 1'b0, 1'b0);
        run("R4 max", 1'b1, 255, 8 * 255 + 4);
        // R6 mask cleared while stable
        @(negedge clk);
        mask_wr = 1'b1; mask_val = 1'b0;
        @(posedge clk);
        @(negedge clk);
        mask_wr = 1'b0; mask_m = 1'b0;
        chk("R6 masked irq", int'(osc_irq), 0);
        chk("R6 stable kept", int'(osc_stable), 1);
        // R7 disabling write
        do_write(1'b0, 5, 1'b1, 1'b1);
        run("R7", 1'b0, 5, 60);
        // R8 rewrite mid-countdown, R3 prescaler restart
        do_write(1'b1, 10, 1'b0, 1'b0);
        run("R8 first", 1'b1, 10, 37);
        do_write(1'b1, 2, 1'b0, 1'b0);
        run("R8 R3 restart", 1'b1, 2, 25);
        // R2 write over a stable state
        do_write(1'b1, 4, 1'b0, 1'b0);
        chk("R2 cleared", int'(osc_stable), 0);
        chk("R2 loaded", int'(cnt_value), 4);

        // constrained random scenarios
        for (int i = 0; i < 30; i++) begin
            bit on;
            bit m;
            int n;
            int kmax;
            on = ($urandom % 5) != 0;
            m  = $urandom % 2;
            n  = ($urandom % 8 == 0) ? int'($urandom % 256) : int'($urandom % 24);
            if ($urandom % 3 == 0) kmax = $urandom % (8 * n + 2);
            else                   kmax = 8 * ((n < 1) ? 1 : n) + int'($urandom % 12);
            do_write(on, n, 1'b1, m);
            run("R3 rand", on, n, kmax);
        end
        finish_up();
    end
endmodule